// File: doc/BRIEF.md
# Clock Mode and Stop-Recovery Controller

This block turns two oscillator strobes into the enable pulse that paces the processor core. A fast main oscillator and a slow sub-clock each arrive as a one-cycle clock-enable strobe. A two-bit speed field selects one of three rates: fast (main divided by 2), medium (main divided by 8) or slow (sub-clock divided by 2). A requested speed change is applied only when the current divided period completes. This keeps every output period whole.

Two low-power requests are supported. A halt request gates only the core pulse, and the divider keeps running. A deep-stop request also stops the main oscillator. An interrupt ends either state. Leaving deep stop, and leaving reset, passes through a settling delay. In that delay the active source, divided by 16, clocks an 8-bit prescaler, and the prescaler's underflows clock an 8-bit timer. The core pulse returns only after the timer underflows. A configuration bit sets where the delay comes from: a fixed hardware preload, or the values software has placed on the two load buses.

Top module: `clkmode_ctrl`

## Requirements
- R1: The speed field encodes 00 as fast, 01 as medium and 10 as slow. In fast mode `phi_en` pulses on every second `main_tick`, in medium mode on every eighth `main_tick`, and in slow mode on every second `sub_tick`. Two pulses are never in adjacent cycles.
- R2: A request for slow mode (10) while `sub_en` is 0 is ignored, and the current speed stays in force. Code 11 is also ignored.
- R3: A new speed takes effect only at the edge that completes the current divided period, and the next period then starts from zero.
- R4: A stop request while running drops `main_run` in the next cycle, and `phi_en` stays low for as long as `main_run` is low.
- R5: With `stab_manual` at 0, a stop loads the prescaler with 0xFF and the timer with 0x01, whatever is on `sw_pre` and `sw_tmr`. From the interrupt that ends the stop, the settling delay is 512 divide-by-16 ticks of the source.
- R6: With `stab_manual` at 1, a stop loads `sw_pre` (P) and `sw_tmr` (T). The delay is 16·(P+1)·(T+1) source ticks.
- R7: The settling delay counts the oscillator of the speed that was active when the stop was taken: sub-clock ticks in slow mode.
- R8: A halt request gates `phi_en` and keeps `main_run` high, while the divider keeps counting. An interrupt resumes pulses at the next period edge, with no settling delay.
- R9: While running, an interrupt has no effect. A stop request takes priority over a simultaneous halt request.
- R10: Reset selects fast mode, holds `main_run` high, clears halt and stop, and applies the automatic settling delay (0xFF / 0x01) before the first `phi_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main oscillator edge strobe |
| sub_tick | input | 1 | Sub-clock edge strobe |
| mode_sel | input | 2 | Requested speed (00 fast, 01 medium, 10 slow) |
| sub_en | input | 1 | Sub-clock enabled; permits slow mode |
| stab_manual | input | 1 | 1: settling values come from the load buses |
| sw_pre | input | 8 | Software prescaler load value |
| sw_tmr | input | 8 | Software timer load value |
| stop_req | input | 1 | Deep-stop request (one cycle) |
| wait_req | input | 1 | Halt request (one cycle) |
| irq | input | 1 | Interrupt request; ends halt or stop |
| phi_en | output | 1 | Core clock enable pulse |
| main_run | output | 1 | Main oscillator running |

## Verification
A divider count or committed speed that is wrong shows up as a `phi_en` pulse placed off the expected edge within one divided period, at most eight source ticks. A wrong prescaler or timer preload cannot be seen while the settling delay runs. It shows only as a first pulse that comes early or late, so the delay from wake to first pulse is measured exactly against 16·(P+1)·(T+1)+2 cycles. A lost stop or halt state shows up at once as `main_run` or `phi_en` disagreeing with the reference model in the cycle after the request.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [1:0] {
        MODE_HIGH = 2'b00,
        MODE_MID  = 2'b01,
        MODE_LOW  = 2'b10
    } spd_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WAIT,
        ST_STOP,
        ST_RECOV
    } pst_t;

    // Speed committed at a period boundary; slow needs the sub-clock enabled.
    function automatic spd_t next_mode(spd_t cur, logic [1:0] req, logic sub_ok);
        case (req)
            2'b00:   return MODE_HIGH;
            2'b01:   return MODE_MID;
            2'b10:   return sub_ok ? MODE_LOW : cur;
            default: return cur;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/clkmode_div.sv
module clkmode_div
    import clkmode_pkg::*;
#(
    parameter int HS_DIV = 2,
    parameter int MS_DIV = 8,
    parameter int LS_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic [1:0] mode_req,
    input  logic       sub_en,
    output spd_t       act_mode,
    output logic       src_tick,
    output logic       bound
);
    localparam int MAXD  = max3(HS_DIV, MS_DIV, LS_DIV);
    localparam int CNT_W = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [CNT_W-1:0] HS_LAST = CNT_W'(HS_DIV - 1);
    localparam logic [CNT_W-1:0] MS_LAST = CNT_W'(MS_DIV - 1);
    localparam logic [CNT_W-1:0] LS_LAST = CNT_W'(LS_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        src_tick = (act_mode == MODE_LOW) ? sub_tick : main_tick;
        case (act_mode)
            MODE_MID: last = MS_LAST;
            MODE_LOW: last = LS_LAST;
            default:  last = HS_LAST;
        endcase
    end

    assign bound = run && src_tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_mode <= MODE_HIGH;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && src_tick) begin
            if (cnt == last) begin
                cnt      <= '0;
                act_mode <= next_mode(act_mode, mode_req, sub_en);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkmode_stab.sv
module clkmode_stab #(
    parameter int                PRE_W    = 8,
    parameter int                TMR_W    = 8,
    parameter int                SRC_DIV  = 16,
    parameter logic [PRE_W-1:0]  AUTO_PRE = '1,
    parameter logic [TMR_W-1:0]  AUTO_TMR = TMR_W'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             manual,
    input  logic [PRE_W-1:0] sw_pre,
    input  logic [TMR_W-1:0] sw_tmr,
    input  logic             cnt_en,
    input  logic             src_tick,
    output logic             done
);
    localparam int SD_W = (SRC_DIV > 2) ? $clog2(SRC_DIV) : 1;
    localparam logic [SD_W-1:0] SD_LAST = SD_W'(SRC_DIV - 1);

    logic [SD_W-1:0]  ps;
    logic [PRE_W-1:0] pre, rld;
    logic [TMR_W-1:0] tmr;
    logic             tick16, pre_uf;

    assign tick16 = cnt_en && src_tick && (ps == SD_LAST);
    assign pre_uf = tick16 && (pre == '0);
    assign done   = pre_uf && (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps  <= '0;
            pre <= AUTO_PRE;
            rld <= AUTO_PRE;
            tmr <= AUTO_TMR;
        end else if (load) begin
            ps  <= '0;
            pre <= manual ? sw_pre : AUTO_PRE;
            rld <= manual ? sw_pre : AUTO_PRE;
            tmr <= manual ? sw_tmr : AUTO_TMR;
        end else if (cnt_en && src_tick) begin
            ps <= (ps == SD_LAST) ? '0 : ps + 1'b1;
            if (tick16) begin
                if (pre == '0) begin
                    pre <= rld;
                    if (tmr != '0) tmr <= tmr - 1'b1;
                end else begin
                    pre <= pre - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
    import clkmode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic wait_req,
    input  logic irq,
    input  logic stab_done,
    output pst_t st,
    output logic stop_load
);
    assign stop_load = (st == ST_RUN) && stop_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_RECOV;
        end else begin
            case (st)
                ST_RUN: begin
                    if (stop_req)      st <= ST_STOP;
                    else if (wait_req) st <= ST_WAIT;
                end
                ST_WAIT:  if (irq)       st <= ST_RUN;
                ST_STOP:  if (irq)       st <= ST_RECOV;
                default:  if (stab_done) st <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int PRE_W   = 8,
    parameter int TMR_W   = 8,
    parameter int SRC_DIV = 16,
    parameter int HS_DIV  = 2,
    parameter int MS_DIV  = 8,
    parameter int LS_DIV  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             main_tick,
    input  logic             sub_tick,
    input  logic [1:0]       mode_sel,
    input  logic             sub_en,
    input  logic             stab_manual,
    input  logic [PRE_W-1:0] sw_pre,
    input  logic [TMR_W-1:0] sw_tmr,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic             irq,
    output logic             phi_en,
    output logic             main_run
);
    pst_t st;
    spd_t act_mode;
    logic stop_load, stab_done, src_tick, bound;

    clkmode_fsm u_fsm (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
        .irq(irq), .stab_done(stab_done), .st(st), .stop_load(stop_load)
    );

    clkmode_div #(.HS_DIV(HS_DIV), .MS_DIV(MS_DIV), .LS_DIV(LS_DIV)) u_div (
        .clk(clk), .rst(rst), .clr(stop_load),
        .run((st == ST_RUN) || (st == ST_WAIT)),
        .main_tick(main_tick), .sub_tick(sub_tick), .mode_req(mode_sel),
        .sub_en(sub_en), .act_mode(act_mode), .src_tick(src_tick), .bound(bound)
    );

    clkmode_stab #(.PRE_W(PRE_W), .TMR_W(TMR_W), .SRC_DIV(SRC_DIV)) u_stab (
        .clk(clk), .rst(rst), .load(stop_load), .manual(stab_manual),
        .sw_pre(sw_pre), .sw_tmr(sw_tmr), .cnt_en(st == ST_RECOV),
        .src_tick(src_tick), .done(stab_done)
    );

    assign phi_en   = bound && (st == ST_RUN);
    assign main_run = (st != ST_STOP);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
    import clkmode_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic stop_req,
    input logic wait_req,
    input logic irq,
    input logic phi_en,
    input logic main_run,
    input logic bound,
    input pst_t st,
    input spd_t act_mode
);
    // R4
    stop_gates_phi_chk: assert property (@(posedge clk) disable iff (rst)
        !main_run |-> !phi_en);
    // R4
    stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && stop_req) |=> !main_run);
    // R9
    stop_over_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && stop_req && wait_req) |=> (st == ST_STOP));
    // R9
    irq_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !stop_req && !wait_req) |=> (st == ST_RUN));
    // R8
    wait_keeps_main_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (main_run && !phi_en));
    // R8
    wait_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && irq) |=> (st == ST_RUN));
    // R1
    phi_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        phi_en |=> !phi_en);
    // R3
    mode_at_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_mode) |-> $past(bound));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
    .irq(irq), .phi_en(phi_en), .main_run(main_run), .bound(bound),
    .st(st), .act_mode(act_mode)
);

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, main_tick, sub_tick, sub_en, stab_manual, stop_req, wait_req, irq;
    logic [1:0] mode_sel;
    logic [7:0] sw_pre, sw_tmr;
    logic phi_en, main_run;

    clkmode_ctrl u_dut (
        .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
        .mode_sel(mode_sel), .sub_en(sub_en), .stab_manual(stab_manual),
        .sw_pre(sw_pre), .sw_tmr(sw_tmr), .stop_req(stop_req),
        .wait_req(wait_req), .irq(irq), .phi_en(phi_en), .main_run(main_run)
    );

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R10";
    bit started = 0, finished = 0, gap_on = 0;

    // reference model state: 0 run, 1 halt, 2 stop, 3 settling
    int ms, mm, mc, mps, mpre, mrld, mtmr;
    logic msrc, ephi;

    function automatic int lim_of(int m);
        return (m == 1) ? 8 : 2;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // oscillator strobes
    initial begin
        main_tick = 1'b1; sub_tick = 1'b0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            sub_tick  = (cyc % 5 == 0);
            main_tick = gap_on ? (cyc % 3 == 0) : 1'b1;
        end
    end

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            ms = 3; mm = 0; mc = 0; mps = 0; mpre = 255; mrld = 255; mtmr = 1;
        end else begin
            msrc = (mm == 2) ? sub_tick : main_tick;
            if (ms == 0 && stop_req) begin
                ms = 2; mc = 0; mps = 0;
                if (stab_manual) begin mpre = sw_pre; mrld = sw_pre; mtmr = sw_tmr; end
                else begin mpre = 255; mrld = 255; mtmr = 1; end
            end else if (ms <= 1) begin
                if (msrc) begin
                    if (mc == lim_of(mm) - 1) begin
                        mc = 0;
                        if (mode_sel == 2'b00) mm = 0;
                        else if (mode_sel == 2'b01) mm = 1;
                        else if (mode_sel == 2'b10 && sub_en) mm = 2;
                    end else mc++;
                end
                if (ms == 0 && wait_req) ms = 1;
                else if (ms == 1 && irq) ms = 0;
            end else if (ms == 2) begin
                if (irq) ms = 3;
            end else if (msrc) begin
                if (mps == 15) begin
                    mps = 0;
                    if (mpre == 0) begin
                        mpre = mrld;
                        if (mtmr == 0) ms = 0; else mtmr--;
                    end else mpre--;
                end else mps++;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            msrc = (mm == 2) ? sub_tick : main_tick;
            ephi = (ms == 0) && msrc && (mc == lim_of(mm) - 1);
            chk(phi_en === ephi, cur_req, phi_en, ephi);
            chk(main_run === (ms != 2), cur_req, main_run, ms != 2);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic count_phi(int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (phi_en) c++; end
        @(posedge clk); #1;
    endtask

    task automatic first_phi(output int k);
        k = 0;
        do begin @(negedge clk); k++; end while (!phi_en && k < 20000);
        @(posedge clk); #1;
    endtask

    task automatic pulse_irq();
        irq = 1'b1; tick(1); irq = 1'b0;
    endtask

    task automatic do_stop(string req);
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        @(negedge clk);
        chk(main_run == 1'b0, req, main_run, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        int c, k;
        rst = 1'b1; mode_sel = 2'b00; sub_en = 0; stab_manual = 0;
        sw_pre = 8'd3; sw_tmr = 8'd2; stop_req = 0; wait_req = 0; irq = 0;
        tick(2);
        @(negedge clk);
        chk(main_run == 1'b1 && phi_en == 1'b0, "R10 reset outputs", {main_run, phi_en}, 2);
        @(posedge clk); #1; rst = 1'b0;
        first_phi(k);
        chk(k == 8194, "R10 first pulse after reset", k, 8194);

        cur_req = "R1";
        count_phi(20, c);
        chk(c == 10, "R1 fast rate", c, 10);
        gap_on = 1; tick(30); gap_on = 0;

        cur_req = "R3";
        mode_sel = 2'b01; tick(20);
        count_phi(64, c);
        chk(c == 8, "R1 medium rate", c, 8);

        cur_req = "R2";
        mode_sel = 2'b10; sub_en = 0; tick(16);
        count_phi(64, c);
        chk(c == 8, "R2 slow refused without sub_en", c, 8);

        cur_req = "R1";
        sub_en = 1; tick(30);
        count_phi(100, c);
        chk(c == 10, "R1 slow rate", c, 10);

        cur_req = "R7";
        stab_manual = 1; sw_pre = 8'd0; sw_tmr = 8'd0;
        do_stop("R4 stop in slow");
        tick(5); pulse_irq();
        first_phi(k);
        chk(k >= 80 && k <= 100, "R7 settling on sub-clock", k, 86);

        cur_req = "R8";
        mode_sel = 2'b00; tick(30);
        wait_req = 1'b1; tick(1); wait_req = 1'b0;
        count_phi(10, c);
        chk(c == 0, "R8 halt gates pulses", c, 0);
        chk(main_run == 1'b1, "R8 halt keeps main", main_run, 1);
        pulse_irq(); tick(20);

        cur_req = "R9";
        pulse_irq();
        count_phi(20, c);
        chk(c == 10, "R9 irq ignored while running", c, 10);
        stop_req = 1'b1; wait_req = 1'b1; tick(1); stop_req = 1'b0; wait_req = 1'b0;
        @(negedge clk);
        chk(main_run == 1'b0, "R9 stop wins over halt", main_run, 0);
        @(posedge clk); #1;
        tick(3); pulse_irq();
        first_phi(k);
        chk(k == 18, "R6 zero preload delay", k, 18);

        cur_req = "R5";
        stab_manual = 0; sw_pre = 8'd3; sw_tmr = 8'd2;
        do_stop("R4 stop in fast");
        count_phi(10, c);
        chk(c == 0, "R4 no pulse while stopped", c, 0);
        pulse_irq();
        first_phi(k);
        chk(k == 8194, "R5 automatic preload delay", k, 8194);

        cur_req = "R6";
        stab_manual = 1;
        do_stop("R4 stop manual");
        tick(4); pulse_irq();
        first_phi(k);
        chk(k == 194, "R6 software preload delay", k, 194);

        tick(10);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule